// File: doc/BRIEF.md
# Pseudo-Static RAM Host Controller

This controller connects a synchronous request port to an asynchronous 128K x 8 pseudo-static RAM. A requester presents a read or a write with a 17-bit byte address and holds it until `req_ready_o` accepts it. The controller then produces a chip-enable pulse of fixed clock length, with output enable or read/write, address and data bus enable shaped around that pulse. Read data comes back on a one-cycle strobe.

Every pin timing is a parameter counted in cycles of a 100 MHz clock. After reset the device is kept deselected for a power-up pause. An interval counter requests one auto-refresh about every 15.6 µs, which meets the budget of 512 refreshes in 8 ms. A pending refresh is served before any new request, but it never cuts into an access that has already started. Refresh is a bounded low pulse on a dedicated pin, and it is issued only while chip enable is high.

Top module: `psram_ctrl`

## Requirements
- R1: While `rst_ni` is low: `ce1_n_o`, `oe_n_o`, `rw_n_o` and `rfsh_n_o` are 1; `ce2_o`, `req_ready_o`, `dq_oe_o` and `rsp_valid_o` are 0.
- R2: After reset, `ce1_n_o` stays 1, `ce2_o` stays 0 and `req_ready_o` stays 0 for POWERUP_CYC clock edges. `ce2_o` rises at that edge and then stays 1.
- R3: A read accepted at a clock edge drives `ce1_n_o` and `oe_n_o` to 0 from that edge for exactly CE_LOW_CYC cycles. During that time `rw_n_o` stays 1 and `addr_o` holds the accepted address.
- R4: For a read, `dq_i` is sampled at the clock edge RD_ACCESS_CYC+1 cycles after `ce1_n_o` fell. `rsp_valid_o` is 1 for the one following cycle, with the sampled byte on `rsp_rdata_o`. Reads complete in the order they were accepted.
- R5: A write drives `ce1_n_o` and `rw_n_o` to 0 together for CE_LOW_CYC cycles, with `oe_n_o` held at 1. `dq_oe_o` is 1 and `dq_o` carries the write byte from the fall of `ce1_n_o` until CE_PRE_CYC cycles after it rises. A write gives no `rsp_valid_o`.
- R6: After `ce1_n_o` rises it stays 1 for at least CE_PRE_CYC+1 cycles before it falls again.
- R7: A refresh becomes pending every REFRESH_INTERVAL_CYC cycles after reset. A pending refresh drives `rfsh_n_o` to 0 for exactly RFSH_LOW_CYC cycles, only while `ce1_n_o` is 1. No access starts within the next RFSH_HIGH_CYC cycles.
- R8: `req_ready_o` is 1 only when the controller is idle and no refresh is pending. A refresh that becomes pending during an access waits until that access and its precharge have finished.
- R9: `dq_oe_o` is never 1 while a read holds `ce1_n_o` low, and `oe_n_o` and `rw_n_o` are never 0 at the same time.
- R10: `ce2_o` is 0 during the power-up pause and 1 after it, so the device stays deselected by both enables until the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted at this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_rdata_o | output | 8 | Read byte |
| rsp_valid_o | output | 1 | Read byte valid, one cycle |
| ce1_n_o | output | 1 | Chip enable, active low |
| ce2_o | output | 1 | Chip enable, active high |
| oe_n_o | output | 1 | Output enable, active low |
| rw_n_o | output | 1 | 1 = read, 0 = write |
| rfsh_n_o | output | 1 | Refresh request, active low |
| addr_o | output | 17 | Address pins |
| dq_o | output | 8 | Data bus outbound value |
| dq_oe_o | output | 1 | Data bus driver enable |
| dq_i | input | 8 | Data bus inbound value |

## Verification
Two events can fall on the same clock edge: the refresh interval counter sets its pending flag, and a request is accepted. The bench holds `req_valid_i` high almost all the time with short gaps, so over several refresh intervals the tick lands in idle cycles, on accept edges and in the middle of accesses. A cycle-by-cycle reference model predicts every pin. It checks that the access accepted on a collision edge runs to its full width, and that the refresh follows only after the precharge, with the request port held off until the refresh high phase has elapsed. A long idle stretch shows that refresh is served with no traffic at all.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_ACCESS,
    ST_PRECH,
    ST_RF_LOW,
    ST_RF_HIGH
  } seq_state_e;
endpackage

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pending_o
);
  localparam int CNT_W = $clog2(INTERVAL_CYC + 1);

  logic [CNT_W-1:0] tick_cnt;
  logic             tick;

  assign tick = (tick_cnt == CNT_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt  <= '0;
      pending_o <= 1'b0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)       pending_o <= 1'b1;
      else if (ack_i) pending_o <= 1'b0;
    end
  end

  // R7
  pending_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !ack_i) |=> pending_o);
endmodule

// File: rtl/psram_cycle_fsm.sv
module psram_cycle_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int POWERUP_CYC   = 10000,
  parameter int CE_LOW_CYC    = 11,
  parameter int CE_PRE_CYC    = 6,
  parameter int RD_ACCESS_CYC = 10,
  parameter int RFSH_LOW_CYC  = 4,
  parameter int RFSH_HIGH_CYC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pending_i,
  output logic              ack_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              ce1_n_o,
  output logic              ce2_o,
  output logic              oe_n_o,
  output logic              rw_n_o,
  output logic              rfsh_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int CNT_W = $clog2(POWERUP_CYC + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             is_wr;

  assign ack_o       = (state == ST_IDLE) && pending_i;
  assign req_ready_o = (state == ST_IDLE) && !pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_INIT;
      cnt         <= '0;
      is_wr       <= 1'b0;
      ce1_n_o     <= 1'b1;
      ce2_o       <= 1'b0;
      oe_n_o      <= 1'b1;
      rw_n_o      <= 1'b1;
      rfsh_n_o    <= 1'b1;
      addr_o      <= '0;
      dq_o        <= '0;
      dq_oe_o     <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state)
        ST_INIT: begin
          if (cnt == CNT_W'(POWERUP_CYC - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ce2_o <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_IDLE: begin
          cnt <= '0;
          if (pending_i) begin
            rfsh_n_o <= 1'b0;
            state    <= ST_RF_LOW;
          end else if (req_valid_i) begin
            ce1_n_o <= 1'b0;
            oe_n_o  <= req_write_i;
            rw_n_o  <= !req_write_i;
            addr_o  <= req_addr_i;
            dq_o    <= req_wdata_i;
            dq_oe_o <= req_write_i;
            is_wr   <= req_write_i;
            state   <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          cnt <= cnt + 1'b1;
          // data sampled one clock after the access time expires
          if (!is_wr && cnt == CNT_W'(RD_ACCESS_CYC)) begin
            rsp_rdata_o <= dq_i;
            rsp_valid_o <= 1'b1;
          end
          if (cnt == CNT_W'(CE_LOW_CYC - 1)) begin
            ce1_n_o <= 1'b1;
            oe_n_o  <= 1'b1;
            rw_n_o  <= 1'b1;
            cnt     <= '0;
            state   <= ST_PRECH;
          end
        end
        ST_PRECH: begin
          if (cnt == CNT_W'(CE_PRE_CYC - 1)) begin
            dq_oe_o <= 1'b0;
            cnt     <= '0;
            state   <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_RF_LOW: begin
          if (cnt == CNT_W'(RFSH_LOW_CYC - 1)) begin
            rfsh_n_o <= 1'b1;
            cnt      <= '0;
            state    <= ST_RF_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        ST_RF_HIGH: begin
          if (cnt == CNT_W'(RFSH_HIGH_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  // independent width monitor for the chip-enable pulse
  logic [CNT_W-1:0] ce_low_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ce_low_run <= '0;
    else if (!ce1_n_o)   ce_low_run <= ce_low_run + 1'b1;
    else                 ce_low_run <= '0;
  end

  // R3
  ce_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_low_run <= CNT_W'(CE_LOW_CYC));
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_n_o && !$past(ce1_n_o)) |-> $stable(addr_o));
  // R7
  rfsh_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_n_o |-> ce1_n_o);
  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ce1_n_o && rfsh_n_o && !pending_i));
  // R9
  no_read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_n_o && rw_n_o) |-> !dq_oe_o);
  // R9
  oe_rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && !rw_n_o));
  // R10
  ce2_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce2_o) |-> ce2_o);
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int POWERUP_CYC          = 10000,
  parameter int REFRESH_INTERVAL_CYC = 1560,
  parameter int CE_LOW_CYC           = 11,
  parameter int CE_PRE_CYC           = 6,
  parameter int RD_ACCESS_CYC        = 10,
  parameter int RFSH_LOW_CYC         = 4,
  parameter int RFSH_HIGH_CYC        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_valid_o,
  output logic              ce1_n_o,
  output logic              ce2_o,
  output logic              oe_n_o,
  output logic              rw_n_o,
  output logic              rfsh_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  logic rf_pending;
  logic rf_ack;

  psram_refresh_sched #(
    .INTERVAL_CYC(REFRESH_INTERVAL_CYC)
  ) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (rf_ack),
    .pending_o (rf_pending)
  );

  psram_cycle_fsm #(
    .POWERUP_CYC  (POWERUP_CYC),
    .CE_LOW_CYC   (CE_LOW_CYC),
    .CE_PRE_CYC   (CE_PRE_CYC),
    .RD_ACCESS_CYC(RD_ACCESS_CYC),
    .RFSH_LOW_CYC (RFSH_LOW_CYC),
    .RFSH_HIGH_CYC(RFSH_HIGH_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (rf_pending),
    .ack_o       (rf_ack),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_valid_o (rsp_valid_o),
    .ce1_n_o     (ce1_n_o),
    .ce2_o       (ce2_o),
    .oe_n_o      (oe_n_o),
    .rw_n_o      (rw_n_o),
    .rfsh_n_o    (rfsh_n_o),
    .addr_o      (addr_o),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .dq_i        (dq_i)
  );
endmodule

// File: tb/psram_ctrl_bench.sv
`timescale 1ns/1ps
module psram_ctrl_bench;
  localparam int PWR  = 10000;
  localparam int RINT = 1560;
  localparam int CEL  = 11;
  localparam int PRE  = 6;
  localparam int RDA  = 10;
  localparam int RFL  = 4;
  localparam int RFH  = 12;
  localparam int NOPS = 320;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  dq_i = 8'h5A;
  logic        req_ready_o, rsp_valid_o, ce1_n_o, ce2_o, oe_n_o, rw_n_o, rfsh_n_o, dq_oe_o;
  logic [7:0]  rsp_rdata_o, dq_o;
  logic [16:0] addr_o;

  always #5 clk = ~clk;

  psram_ctrl u_psram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_rdata_o(rsp_rdata_o), .rsp_valid_o(rsp_valid_o),
    .ce1_n_o(ce1_n_o), .ce2_o(ce2_o), .oe_n_o(oe_n_o), .rw_n_o(rw_n_o),
    .rfsh_n_o(rfsh_n_o), .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference memory and model ----------------
  logic [7:0] ref_mem [int];
  logic [7:0] dev_mem [int];
  function automatic logic [7:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hC3;
  endfunction
  function automatic logic [7:0] rd_dev(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : 8'hC3;
  endfunction

  int m_init, m_ce, m_pre, m_rfl, m_rfh, m_rfcnt, m_age;
  bit m_pend, m_wr, m_rv, hs_seen;
  logic [16:0] m_addr;
  logic [7:0]  m_wd, m_rd_exp;
  logic [7:0]  rq[$];
  int cyc = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_init = PWR; m_ce = 0; m_pre = 0; m_rfl = 0; m_rfh = 0; m_rfcnt = 0;
      m_age = 0; m_pend = 0; m_wr = 0; m_rv = 0; m_addr = '0; m_wd = '0;
    end else begin
      cyc++;
      m_rv = 0;
      if (m_init > 0) m_init--;
      else if (m_ce > 0) begin
        m_ce--; m_age++;
        if (!m_wr && m_age == RDA + 1) begin
          m_rv = 1;
          m_rd_exp = (rq.size() > 0) ? rq.pop_front() : 8'hxx;
        end
        if (m_ce == 0) m_pre = PRE;
      end
      else if (m_pre > 0) m_pre--;
      else if (m_rfl > 0) begin m_rfl--; if (m_rfl == 0) m_rfh = RFH; end
      else if (m_rfh > 0) m_rfh--;
      else if (m_pend) begin m_pend = 0; m_rfl = RFL; end
      else if (req_valid) begin
        m_ce = CEL; m_age = 0; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
        if (req_write) ref_mem[int'(req_addr)] = req_wdata;
        else rq.push_back(rd_ref(int'(req_addr)));
        hs_seen = 1;
      end
      if (m_rfcnt == RINT - 1) begin m_rfcnt = 0; m_pend = 1; end
      else m_rfcnt++;
    end
  end

  // ---------------- device model ----------------
  bit dv_prev_ce = 1, dv_wr;
  int dv_age = 0, dv_lat = 0;
  logic [7:0] dv_wd;
  int ce_hi_run = 100;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (dv_prev_ce && !ce1_n_o) begin
        chk(ce_hi_run >= PRE + 1, "R6", "ce1 high run", ce_hi_run, PRE + 1);
        dv_lat = int'(addr_o); dv_wr = 0; dv_wd = 8'hEE;
      end
      if (!ce1_n_o && !rw_n_o) begin
        dv_wr = 1;
        dv_wd = dq_oe_o ? dq_o : 8'hEE;
      end
      if (!dv_prev_ce && ce1_n_o && dv_wr) dev_mem[dv_lat] = dv_wd;
      ce_hi_run = ce1_n_o ? ce_hi_run + 1 : 0;
      dv_age = ce1_n_o ? 0 : dv_age + 1;
      dv_prev_ce = ce1_n_o;
      dq_i = (!ce1_n_o && !oe_n_o && rw_n_o && dv_age > RDA) ? rd_dev(dv_lat) : 8'h5A;
      if (dq_oe_o && !ce1_n_o && !oe_n_o)
        chk(0, "R9", "bus contention", 1, 0);
    end
  end

  // ---------------- per-cycle comparison ----------------
  int ce2_rise_cyc = -1;
  always @(negedge clk) begin
    if (!rst_ni) begin
      chk(ce1_n_o && oe_n_o && rw_n_o && rfsh_n_o, "R1", "strobes in reset",
          {ce1_n_o, oe_n_o, rw_n_o, rfsh_n_o}, 4'hF);
      chk(!ce2_o && !req_ready_o && !dq_oe_o && !rsp_valid_o, "R1", "enables in reset",
          {ce2_o, req_ready_o, dq_oe_o, rsp_valid_o}, 0);
    end else begin
      bit e_ready, e_ce1, e_oe, e_rw, e_rf, e_oe_dq;
      e_ready = (m_init == 0 && m_ce == 0 && m_pre == 0 && m_rfl == 0 && m_rfh == 0 && !m_pend);
      e_ce1   = !(m_ce > 0);
      e_oe    = !(m_ce > 0 && !m_wr);
      e_rw    = !(m_ce > 0 && m_wr);
      e_rf    = !(m_rfl > 0);
      e_oe_dq = m_wr && (m_ce > 0 || m_pre > 0);
      if (ce2_o && ce2_rise_cyc < 0) begin
        ce2_rise_cyc = cyc;
        chk(cyc == PWR, "R2", "power-up pause length", cyc, PWR);
      end
      chk(ce2_o == (m_init == 0), "R10", "ce2", ce2_o, m_init == 0);
      chk(ce1_n_o == e_ce1, (m_init > 0) ? "R2" : "R3", "ce1_n", ce1_n_o, e_ce1);
      chk(oe_n_o == e_oe, "R3", "oe_n", oe_n_o, e_oe);
      chk(rw_n_o == e_rw, "R5", "rw_n", rw_n_o, e_rw);
      chk(rfsh_n_o == e_rf, "R7", "rfsh_n", rfsh_n_o, e_rf);
      chk(req_ready_o == e_ready, "R8", "req_ready", req_ready_o, e_ready);
      chk(dq_oe_o == e_oe_dq, "R5", "dq_oe", dq_oe_o, e_oe_dq);
      if (m_ce > 0) chk(addr_o == m_addr, "R3", "addr", addr_o, m_addr);
      if (e_oe_dq)  chk(dq_o == m_wd, "R5", "dq_o", dq_o, m_wd);
      chk(rsp_valid_o == m_rv, "R4", "rsp_valid", rsp_valid_o, m_rv);
      if (m_rv) chk(rsp_rdata_o === m_rd_exp, "R4", "rsp_rdata", rsp_rdata_o, m_rd_exp);
      chk(!(!oe_n_o && !rw_n_o), "R9", "oe and rw both low", {oe_n_o, rw_n_o}, 2'b11);
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] lfsr = 16'hACE1;
  int op_i = 0, pause = 0;
  bit stim_on = 0, stim_done = 0;
  always @(negedge clk) begin
    if (stim_on && !stim_done && (!req_valid || hs_seen)) begin
      hs_seen = 0;
      req_valid <= 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pause > 0) pause--;
      else if (op_i >= NOPS) stim_done = 1;
      else if (op_i == 200 && pause == 0 && lfsr[0] !== 1'bx && m_rfcnt >= 0) begin
        pause = 2000; op_i++;               // long idle: R7 refresh without traffic
      end
      else if (op_i >= 8 && lfsr[3:0] == 4'h0) ;   // short gap
      else begin
        req_valid <= 1'b1;
        if (op_i < 4) begin
          req_write <= 1'b1;
          req_addr  <= (op_i == 0) ? 17'h00000 : (op_i == 1) ? 17'h1FFFF :
                       (op_i == 2) ? 17'h12345 : 17'h0AAAA;
          req_wdata <= 8'h11 * 8'(op_i + 1);
        end else if (op_i < 8) begin
          req_write <= 1'b0;
          req_addr  <= (op_i == 4) ? 17'h00000 : (op_i == 5) ? 17'h1FFFF :
                       (op_i == 6) ? 17'h12345 : 17'h0AAAA;
        end else begin
          req_write <= lfsr[4];
          req_addr  <= {13'h0F0F, lfsr[8:5]};
          req_wdata <= lfsr[15:8];
        end
        op_i++;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    stim_on = 1;
    wait (stim_done);
    req_valid <= 1'b0;
    repeat (60) @(negedge clk);
    chk(rq.size() == 0, "R4", "outstanding reads", rq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule